// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block sits between an external parallel image sensor and the rest of a capture path. The sensor drives a pixel clock, a data bus and three framing lines: data-enable, horizontal sync and vertical sync. The block runs entirely on the system clock. It oversamples the pixel clock, finds its active edge, and takes the bus and framing lines at that edge. The active edge and the polarity of each framing line are set by configuration.

On each active edge the block decides whether the sample carries pixel bytes. It can use either data-enable with vertical sync, or data-enable with horizontal and vertical sync. Vertical sync can first pass through a stability filter. Qualified samples come out as 16-bit words. Wide samples pass through directly. Narrow byte samples are paired into words.

Two programmable counters, each loaded with a value one less than the wanted count, drive the event outputs. One counts line endings and raises a periodic line pulse. The other counts received bytes and raises an end-of-transfer pulse. After that pulse, capture stays halted until the start control is lowered and raised again.

Top module: `cam_capture_front`

## Requirements
- R1: While `rst` or `cfg_cam_reset` is high, all outputs are held low and `out_data` is zero. On the cycle after either is high, `out_valid`, `line_irq` and `eot_pulse` are low. Both resets clear the line count, the byte count, the filter state, the halt state and any pending byte.
- R2: With `cfg_pclk_inv`=0, the active pixel-clock edge is rising. With `cfg_pclk_inv`=1, it is falling. Data and framing lines are sampled at the first rising `clk` edge that sees the active level. The resulting outputs are registered at the following rising `clk` edge.
- R3: Each of `cfg_de_inv`, `cfg_hs_inv` and `cfg_vs_inv`, when 1, inverts its framing input before any qualification, filtering or line detection.
- R4: With `cfg_qual_mode`=1, a sample is valid only if data-enable, horizontal sync and vertical sync are all asserted. With `cfg_qual_mode`=0, a sample is valid when data-enable and vertical sync are asserted, whatever horizontal sync is.
- R5: With `cfg_wide`=1, each valid sample produces one `out_valid` cycle carrying `cam_data[15:0]` unchanged. `out_data` holds its value in cycles where `out_valid` is low.
- R6: With `cfg_wide`=0, only `cam_data[7:0]` is used. Two successive valid bytes produce one word, with the first byte in bits 7:0 and the second byte in bits 15:8. If end-of-transfer falls on an unpaired byte, that byte is emitted at once as `{8'h00, byte}`.
- R7: A line ends on a sample where the line signal was asserted on the previous sample and is deasserted now. The line signal is horizontal sync in mode 1 and data-enable in mode 0. The line count advances at each line ending. When the count already equals `cfg_line_num`, `line_irq` pulses for one cycle, in the output cycle of that sample, and the count returns to zero.
- R8: The byte count advances by 2 per valid wide sample and by 1 per valid narrow sample. When the count reaches `cfg_byte_len`+1 or more, `eot_pulse` pulses for one cycle alongside that sample's output word, and the count returns to zero.
- R9: After `eot_pulse`, further samples produce no words, no byte counting and no line counting. This lasts until `cfg_start` has been low for at least one cycle and is high again.
- R10: With `cfg_vs_filt_en`=1, qualification uses a filtered vertical sync. The filtered level takes a new value only after 4 consecutive samples at that value, and applies from the fifth such sample. Shorter pulses are ignored. With `cfg_vs_filt_en`=0, the sampled vertical sync is used directly.
- R11: A high `cfg_fifo_reset` discards a pending unpaired narrow byte. The next two valid bytes then form a word. The byte count is unaffected.
- R12: While `cfg_start` is low, no word, line pulse or end-of-transfer pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Capture enable |
| cfg_cam_reset | input | 1 | Clears all capture state |
| cfg_fifo_reset | input | 1 | Drops the pending narrow byte |
| cfg_pclk_inv | input | 1 | 1 selects the falling pixel-clock edge |
| cfg_de_inv | input | 1 | Invert data-enable |
| cfg_hs_inv | input | 1 | Invert horizontal sync |
| cfg_vs_inv | input | 1 | Invert vertical sync |
| cfg_qual_mode | input | 1 | 1: data-enable plus both syncs; 0: data-enable plus vertical sync |
| cfg_wide | input | 1 | 1: 16-bit samples; 0: 8-bit samples |
| cfg_vs_filt_en | input | 1 | Use the filtered vertical sync |
| cfg_line_num | input | 8 | Lines per line pulse, minus one |
| cfg_byte_len | input | 16 | Bytes per transfer, minus one |
| cam_pclk | input | 1 | Sensor pixel clock (sampled) |
| cam_data | input | 16 | Sensor data bus |
| cam_de | input | 1 | Sensor data-enable |
| cam_hs | input | 1 | Sensor horizontal sync |
| cam_vs | input | 1 | Sensor vertical sync |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 16 | Output word |
| line_irq | output | 1 | One-cycle line-count pulse |
| eot_pulse | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Synthetic frames are driven with horizontal sync held high during lines in mode 1 and held low in mode 0. This separates the two qualification rules. In mode 1, a data-enable-only gap sample must be dropped even though it ends a line. A narrow frame longer than the programmed length shows odd-byte flushing, the halt after end-of-transfer and re-arming. A short wide transfer shows that counting goes by two. A frame with every polarity control flipped must match the plain frame's behaviour. Vertical-sync pulses of three samples, and runs of six samples, with the filter on and off, pin down the four-sample threshold. Every word and pulse is compared with the system-clock cycle predicted from its pixel edge.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic {
    QUAL_DE_VS    = 1'b0,
    QUAL_DE_HS_VS = 1'b1
  } qual_mode_e;

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } cam_ctl_t;
endpackage

// File: rtl/cam_edge_sampler.sv
module cam_edge_sampler #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              pclk_inv,
  input  logic              de_inv,
  input  logic              hs_inv,
  input  logic              vs_inv,
  input  logic              pclk,
  input  logic [DATA_W-1:0] data_in,
  input  logic              de_in,
  input  logic              hs_in,
  input  logic              vs_in,
  output logic              strobe,
  output logic [DATA_W-1:0] data_q,
  output cam_pkg::cam_ctl_t ctl_q
);
  logic lvl_now, lvl_prev;

  // Level registers reset high so that no edge is seen straight after reset.
  always_ff @(posedge clk) begin
    if (srst) begin
      lvl_now  <= 1'b1;
      lvl_prev <= 1'b1;
      data_q   <= '0;
      ctl_q    <= '0;
    end else begin
      lvl_now  <= pclk ^ pclk_inv;
      lvl_prev <= lvl_now;
      data_q   <= data_in;
      ctl_q.de <= de_in ^ de_inv;
      ctl_q.hs <= hs_in ^ hs_inv;
      ctl_q.vs <= vs_in ^ vs_inv;
    end
  end

  assign strobe = lvl_now & ~lvl_prev;
endmodule

// File: rtl/cam_vsync_filter.sv
module cam_vsync_filter #(
  parameter int STABLE_N = 4
) (
  input  logic clk,
  input  logic srst,
  input  logic strobe,
  input  logic vs_raw,
  output logic vs_filt
);
  localparam int CW = (STABLE_N > 1) ? $clog2(STABLE_N) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_N - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (srst) begin
      vs_filt <= 1'b0;
      run_cnt <= '0;
    end else if (strobe) begin
      if (vs_raw == vs_filt) begin
        run_cnt <= '0;
      end else if (run_cnt == LAST) begin
        vs_filt <= vs_raw;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cam_event_counter.sv
module cam_event_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             en,
  input  logic [1:0]       step,
  input  logic [CNT_W-1:0] target,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   sum;

  assign sum  = {1'b0, cnt} + {{(CNT_W-1){1'b0}}, step};
  assign fire = en && (sum > {1'b0, target});

  always_ff @(posedge clk) begin
    if (srst)    cnt <= '0;
    else if (en) cnt <= fire ? '0 : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/cam_capture_front.sv
module cam_capture_front #(
  parameter int DATA_W   = 16,
  parameter int LINE_W   = 8,
  parameter int LEN_W    = 16,
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_start,
  input  logic              cfg_cam_reset,
  input  logic              cfg_fifo_reset,
  input  logic              cfg_pclk_inv,
  input  logic              cfg_de_inv,
  input  logic              cfg_hs_inv,
  input  logic              cfg_vs_inv,
  input  logic              cfg_qual_mode,
  input  logic              cfg_wide,
  input  logic              cfg_vs_filt_en,
  input  logic [LINE_W-1:0] cfg_line_num,
  input  logic [LEN_W-1:0]  cfg_byte_len,
  input  logic              cam_pclk,
  input  logic [DATA_W-1:0] cam_data,
  input  logic              cam_de,
  input  logic              cam_hs,
  input  logic              cam_vs,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              line_irq,
  output logic              eot_pulse
);
  import cam_pkg::*;

  localparam int BYTE_W = DATA_W / 2;

  logic              srst;
  logic              strobe;
  logic [DATA_W-1:0] s_data;
  cam_ctl_t          s_ctl;
  logic              vs_filt, vs_use;
  qual_mode_e        mode;
  logic              done, active, line_sig, line_prev;
  logic              pix_ok, line_end, line_fire, byte_fire;
  logic [1:0]        byte_step;
  logic              half;
  logic [BYTE_W-1:0] hold;

  assign srst = rst | cfg_cam_reset;
  assign mode = qual_mode_e'(cfg_qual_mode);

  cam_edge_sampler #(.DATA_W(DATA_W)) u_samp (
    .clk(clk), .srst(srst), .pclk_inv(cfg_pclk_inv), .de_inv(cfg_de_inv),
    .hs_inv(cfg_hs_inv), .vs_inv(cfg_vs_inv), .pclk(cam_pclk),
    .data_in(cam_data), .de_in(cam_de), .hs_in(cam_hs), .vs_in(cam_vs),
    .strobe(strobe), .data_q(s_data), .ctl_q(s_ctl)
  );

  cam_vsync_filter #(.STABLE_N(FILT_LEN)) u_vfilt (
    .clk(clk), .srst(srst), .strobe(strobe), .vs_raw(s_ctl.vs), .vs_filt(vs_filt)
  );

  assign vs_use    = cfg_vs_filt_en ? vs_filt : s_ctl.vs;
  assign active    = cfg_start & ~done;
  assign line_sig  = (mode == QUAL_DE_HS_VS) ? s_ctl.hs : s_ctl.de;
  assign pix_ok    = strobe & active & s_ctl.de & vs_use &
                     ((mode == QUAL_DE_VS) | s_ctl.hs);
  assign line_end  = strobe & active & line_prev & ~line_sig;
  assign byte_step = cfg_wide ? 2'd2 : 2'd1;

  cam_event_counter #(.CNT_W(LINE_W)) u_line_cnt (
    .clk(clk), .srst(srst), .en(line_end), .step(2'd1),
    .target(cfg_line_num), .fire(line_fire)
  );

  cam_event_counter #(.CNT_W(LEN_W)) u_byte_cnt (
    .clk(clk), .srst(srst), .en(pix_ok), .step(byte_step),
    .target(cfg_byte_len), .fire(byte_fire)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      line_irq  <= 1'b0;
      eot_pulse <= 1'b0;
      done      <= 1'b0;
      line_prev <= 1'b0;
      half      <= 1'b0;
      hold      <= '0;
    end else begin
      out_valid <= 1'b0;
      line_irq  <= line_fire;
      eot_pulse <= byte_fire;
      if (strobe) line_prev <= line_sig;
      if (byte_fire)       done <= 1'b1;
      else if (!cfg_start) done <= 1'b0;
      if (cfg_fifo_reset) half <= 1'b0;
      if (pix_ok) begin
        if (cfg_wide) begin
          out_valid <= 1'b1;
          out_data  <= s_data;
        end else if (half) begin
          out_valid <= 1'b1;
          out_data  <= {s_data[BYTE_W-1:0], hold};
          half      <= 1'b0;
        end else if (byte_fire) begin
          out_valid <= 1'b1;
          out_data  <= {{BYTE_W{1'b0}}, s_data[BYTE_W-1:0]};
        end else begin
          hold <= s_data[BYTE_W-1:0];
          half <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cam_capture_front_chk.sv
module cam_capture_front_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_start,
  input logic              cfg_cam_reset,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              line_irq,
  input logic              eot_pulse
);
  AST_RESET_QUIETS: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_cam_reset) |-> (!out_valid && !line_irq && !eot_pulse)); // R1

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(cfg_cam_reset)) |-> $stable(out_data)); // R5

  AST_LINE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    line_irq |=> !line_irq); // R7

  AST_EOT_CARRIES_WORD: assert property (@(posedge clk) disable iff (rst)
    eot_pulse |-> out_valid); // R8

  AST_WORD_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(cfg_start)); // R12

  AST_LINE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    line_irq |-> $past(cfg_start)); // R12
endmodule

bind cam_capture_front cam_capture_front_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_cam_capture_front.sv
module tb_cam_capture_front;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_start = 1'b0, cfg_cam_reset = 1'b0, cfg_fifo_reset = 1'b0;
  logic cfg_pclk_inv = 1'b0, cfg_de_inv = 1'b0, cfg_hs_inv = 1'b0, cfg_vs_inv = 1'b0;
  logic cfg_qual_mode = 1'b0, cfg_wide = 1'b0, cfg_vs_filt_en = 1'b0;
  logic [7:0]  cfg_line_num = 8'd0;
  logic [15:0] cfg_byte_len = 16'd0;
  logic cam_pclk = 1'b0, cam_de = 1'b0, cam_hs = 1'b0, cam_vs = 1'b0;
  logic [15:0] cam_data = 16'h0;
  logic out_valid, line_irq, eot_pulse;
  logic [15:0] out_data;

  cam_capture_front dut (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  int total = 0, bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] exp_d[$], got_d[$];
  int exp_wc[$], got_wc[$], exp_l[$], got_l[$], exp_e[$], got_e[$];

  always @(negedge clk) if (!rst) begin
    if (out_valid) begin got_d.push_back(out_data); got_wc.push_back(cyc); end
    if (line_irq)  got_l.push_back(cyc);
    if (eot_pulse) got_e.push_back(cyc);
  end

  // reference state, derived from the requirements
  logic m_done, m_half, m_lprev, m_vf;
  logic [7:0] m_hold;
  int m_bc, m_lc, m_vcnt;
  logic [15:0] seed = 16'h1A2B;

  task automatic mclear();
    m_done = 0; m_half = 0; m_lprev = 0; m_vf = 0; m_hold = 0;
    m_bc = 0; m_lc = 0; m_vcnt = 0;
  endtask

  task automatic check(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic model(logic [15:0] d, logic de, logic hs, logic vs, int c);
    logic vsu, act, lsig, fire;
    int step;
    vsu  = cfg_vs_filt_en ? m_vf : vs;
    act  = cfg_start && !m_done;
    lsig = cfg_qual_mode ? hs : de;
    if (vs == m_vf) m_vcnt = 0;
    else if (m_vcnt == 3) begin m_vf = vs; m_vcnt = 0; end
    else m_vcnt++;
    if (act && m_lprev && !lsig) begin
      if (m_lc == int'(cfg_line_num)) begin exp_l.push_back(c); m_lc = 0; end
      else m_lc++;
    end
    m_lprev = lsig;
    if (act && de && vsu && (!cfg_qual_mode || hs)) begin
      step = cfg_wide ? 2 : 1;
      fire = (m_bc + step) > int'(cfg_byte_len);
      m_bc = fire ? 0 : m_bc + step;
      if (fire) begin exp_e.push_back(c); m_done = 1; end
      if (cfg_wide) begin exp_d.push_back(d); exp_wc.push_back(c); end
      else if (m_half) begin exp_d.push_back({d[7:0], m_hold}); exp_wc.push_back(c); m_half = 0; end
      else if (fire) begin exp_d.push_back({8'h00, d[7:0]}); exp_wc.push_back(c); end
      else begin m_hold = d[7:0]; m_half = 1; end
    end
  endtask

  task automatic pix(logic [15:0] d, logic de, logic hs, logic vs);
    @(negedge clk);
    cam_data = d; cam_de = de ^ cfg_de_inv; cam_hs = hs ^ cfg_hs_inv;
    cam_vs = vs ^ cfg_vs_inv; cam_pclk = ~cfg_pclk_inv;
    model(d, de, hs, vs, cyc + 2);
    @(negedge clk); @(negedge clk);
    cam_pclk = cfg_pclk_inv;
    @(negedge clk);
  endtask

  task automatic frame(int nlines, int npix, logic line_hs, logic gap_de);
    for (int i = 0; i < 6; i++) pix(16'h0, 0, 0, 1);
    for (int l = 0; l < nlines; l++) begin
      for (int p = 0; p < npix; p++) begin
        pix(seed, 1, line_hs, 1);
        seed = seed + 16'h1357;
      end
      pix(16'hDEAD, gap_de, 0, 1);
    end
    pix(16'h0, 0, 0, 0); pix(16'h0, 0, 0, 0);
  endtask

  task automatic configure(logic mode, logic wide, logic [7:0] ln, logic [15:0] bl,
                           logic pinv, logic dinv, logic hinv, logic vinv, logic filt);
    @(negedge clk);
    cfg_cam_reset = 1;
    cfg_qual_mode = mode; cfg_wide = wide; cfg_line_num = ln; cfg_byte_len = bl;
    cfg_pclk_inv = pinv; cfg_de_inv = dinv; cfg_hs_inv = hinv; cfg_vs_inv = vinv;
    cfg_vs_filt_en = filt; cam_pclk = pinv;
    cam_de = dinv; cam_hs = hinv; cam_vs = vinv;
    mclear();
    repeat (3) @(negedge clk);
    cfg_cam_reset = 0; cfg_start = 1;
    @(negedge clk);
  endtask

  task automatic compare(string tag);
    int n;
    repeat (3) @(negedge clk);
    check(got_wc.size() == exp_wc.size(), tag, "word count", got_wc.size(), exp_wc.size());
    n = (got_wc.size() < exp_wc.size()) ? got_wc.size() : exp_wc.size();
    for (int i = 0; i < n; i++) begin
      check(got_d[i] == exp_d[i], tag, "word data", got_d[i], exp_d[i]);
      check(got_wc[i] == exp_wc[i], tag, "word cycle", got_wc[i], exp_wc[i]);
    end
    check(got_l.size() == exp_l.size(), tag, "line pulse count", got_l.size(), exp_l.size());
    n = (got_l.size() < exp_l.size()) ? got_l.size() : exp_l.size();
    for (int i = 0; i < n; i++) check(got_l[i] == exp_l[i], tag, "line pulse cycle", got_l[i], exp_l[i]);
    check(got_e.size() == exp_e.size(), tag, "eot count", got_e.size(), exp_e.size());
    n = (got_e.size() < exp_e.size()) ? got_e.size() : exp_e.size();
    for (int i = 0; i < n; i++) check(got_e[i] == exp_e[i], tag, "eot cycle", got_e[i], exp_e[i]);
    exp_d.delete(); got_d.delete(); exp_wc.delete(); got_wc.delete();
    exp_l.delete(); got_l.delete(); exp_e.delete(); got_e.delete();
  endtask

  task automatic t_reset();
    rst = 1; mclear();
    repeat (4) @(negedge clk);
    check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    check(out_data == 0, "R1", "out_data in reset", out_data, 0);
    check(line_irq == 0 && eot_pulse == 0, "R1", "pulses in reset", {line_irq, eot_pulse}, 0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_wide_mode1();
    configure(1, 1, 8'd1, 16'd999, 0, 0, 0, 0, 0);
    frame(4, 3, 1, 1);                       // gap sample has DE without HSYNC
    compare("R4 R5 R7 mode1 wide");
  endtask

  task automatic t_narrow_mode0();
    configure(0, 0, 8'd0, 16'd10, 0, 0, 0, 0, 0);
    frame(4, 4, 0, 0);                       // HSYNC low throughout: ignored
    compare("R4 R6 R8 narrow eot odd");
    frame(1, 2, 0, 0);
    compare("R9 halted after eot");
    @(negedge clk); cfg_start = 0; m_done = 0;
    repeat (2) @(negedge clk); cfg_start = 1;
    frame(1, 4, 0, 0);
    compare("R9 rearm");
    configure(1, 1, 8'd7, 16'd5, 0, 0, 0, 0, 0);
    frame(1, 4, 1, 0);
    compare("R8 wide counts two");
  endtask

  task automatic t_invert();
    configure(1, 1, 8'd2, 16'd999, 1, 1, 1, 1, 0);
    frame(3, 2, 1, 1);
    compare("R2 R3 inverted polarity");
  endtask

  task automatic t_filter();
    configure(0, 1, 8'd9, 16'd999, 0, 0, 0, 0, 1);
    frame(2, 3, 0, 0);
    compare("R10 filtered frame");
    for (int i = 0; i < 5; i++) pix(16'h0, 0, 0, 0);
    for (int i = 0; i < 3; i++) pix(16'hA000 + 16'(i), 1, 0, 1);
    for (int i = 0; i < 5; i++) pix(16'h0, 0, 0, 0);
    compare("R10 short pulse filtered");
    for (int i = 0; i < 6; i++) pix(16'hB000 + 16'(i), 1, 0, 1);
    for (int i = 0; i < 5; i++) pix(16'h0, 0, 0, 0);
    compare("R10 four sample threshold");
    @(negedge clk); cfg_vs_filt_en = 0;
    for (int i = 0; i < 3; i++) pix(16'hC000 + 16'(i), 1, 0, 1);
    pix(16'h0, 0, 0, 0);
    compare("R10 bypass");
  endtask

  task automatic t_fifo_reset();
    configure(0, 0, 8'd9, 16'd999, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) pix(16'h0, 0, 0, 1);
    pix(16'h0011, 1, 0, 1);
    pix(16'h0, 0, 0, 1);
    @(negedge clk); cfg_fifo_reset = 1; m_half = 0;
    @(negedge clk); cfg_fifo_reset = 0;
    pix(16'h0022, 1, 0, 1);
    pix(16'h0033, 1, 0, 1);
    pix(16'h0, 0, 0, 0);
    compare("R11 pending byte dropped");
  endtask

  task automatic t_start_low();
    configure(1, 1, 8'd0, 16'd999, 0, 0, 0, 0, 0);
    @(negedge clk); cfg_start = 0;
    frame(2, 3, 1, 0);
    compare("R12 start low");
    @(negedge clk); cfg_start = 1;
    frame(1, 2, 1, 0);
    compare("R12 start high again");
  endtask

  task automatic t_cam_reset();
    configure(0, 0, 8'd1, 16'd999, 0, 0, 0, 0, 0);
    frame(1, 2, 0, 0);
    @(negedge clk); cfg_cam_reset = 1; mclear();
    repeat (2) @(negedge clk); cfg_cam_reset = 0;
    frame(1, 2, 0, 0);
    compare("R1 line count cleared");
    frame(1, 2, 0, 0);
    compare("R1 R7 line pulse after reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mclear();
    t_reset();
    t_wide_mode1();
    t_narrow_mode0();
    t_invert();
    t_filter();
    t_fifo_reset();
    t_start_low();
    t_cam_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule